// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This block drives memory traffic for a load-multiple or store-multiple operation. A request carries a 16-bit select vector with one bit per register, a base byte address, a direction flag (count up or count down) and a timing flag (move the base before or after the first access). Once the request is taken, the sequencer issues one memory transaction for each selected register. Each transaction carries the register index and a word address, and each completes through a valid/ready handshake.

Transactions always run from the lowest-numbered selected register upward, and the addresses climb by one word (4 bytes) per transaction. The lowest selected register therefore always lands at the lowest address, including in the count-down modes. The first address is computed up front from the base, the mode and the number of selected registers. The updated base value, which the caller may write back, is presented together with a one-cycle completion pulse. Register data and the memory itself are outside the block.

Top module: `blk_xfer_seq`

## Requirements
- R1: `req_ready_o` is high only while the sequencer is idle. A request is taken on a clock edge where both `req_valid_i` and `req_ready_o` are high. Requests presented while busy have no effect on the transactions in flight or on the write-back value.
- R2: One transaction is issued per set bit of the select vector. `mem_reg_o` visits the set bit positions in ascending order starting from bit 0. Cleared bits take no cycles, so with `mem_ready_i` held high the transactions run back to back.
- R3: Consecutive transactions use addresses that differ by +4, so the lowest selected register gets the lowest address.
- R4: With n set bits and base B, the first address depends on `req_dec_i` (1 = count down) and `req_before_i` (1 = before). Up/after gives B. Up/before gives B+4. Down/after gives B-4n+4. Down/before gives B-4n.
- R5: While `mem_valid_o` is high and `mem_ready_i` is low, `mem_valid_o`, `mem_reg_o` and `mem_addr_o` stay unchanged.
- R6: When `done_o` is high, `wb_base_o` equals B+4n when counting up and B-4n when counting down.
- R7: `done_o` is a single-cycle pulse in the cycle after the last handshake. For an all-zero select vector it appears in the cycle after acceptance, and no transaction is issued.
- R8: After reset, `req_ready_o` is high and `mem_valid_o` and `done_o` are low.
- R9: All address arithmetic wraps modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Sequencer idle, request can be taken |
| req_mask_i | input | 16 | Register select vector, bit i selects register i |
| req_base_i | input | AW (32) | Base byte address |
| req_dec_i | input | 1 | 1 = count down, 0 = count up |
| req_before_i | input | 1 | 1 = base moves before first access, 0 = after |
| mem_valid_o | output | 1 | Memory transaction present |
| mem_ready_i | input | 1 | Memory accepts transaction |
| mem_reg_o | output | 4 | Register index of transaction |
| mem_addr_o | output | AW (32) | Word address of transaction |
| wb_base_o | output | AW (32) | Updated base, valid with done_o |
| done_o | output | 1 | Completion pulse |

## Verification
Two situations are hardest to reach from the ports. The first is a new request arriving while a transfer is stalled on its last transaction: the request must be ignored, and done must still arrive exactly one cycle after the late handshake. The second is a count-down transfer whose start address wraps below zero. Directed runs cover every mode, the empty and full select vectors, a forced stall and the wraparound case. A long random phase then toggles the request valid, all request fields and memory ready every cycle, so requests keep colliding with busy periods. Every cycle is compared against a queue-based model.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
  localparam int unsigned NREG       = 16;
  localparam int unsigned WORD_BYTES = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/mask_popcnt.sv
module mask_popcnt #(
  parameter int unsigned W  = 16,
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  mask_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) cnt_o = cnt_o + CW'(mask_i[i]);
  end
endmodule

// File: rtl/lowest_set.sv
module lowest_set #(
  parameter int unsigned W  = 16,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
    any_o = |vec_i;
  end
endmodule

// File: rtl/xfer_addr_calc.sv
module xfer_addr_calc #(
  parameter int unsigned AW         = 32,
  parameter int unsigned CW         = 5,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          dec_i,
  input  logic          before_i,
  output logic [AW-1:0] start_o,
  output logic [AW-1:0] wb_o
);
  localparam int unsigned SH = $clog2(WORD_BYTES);
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  logic [AW-1:0] span;
  assign span = AW'(cnt_i) << SH;

  always_comb begin
    if (dec_i) begin
      wb_o    = base_i - span;
      start_o = before_i ? wb_o : wb_o + STEP;
    end else begin
      wb_o    = base_i + span;
      start_o = before_i ? base_i + STEP : base_i;
    end
  end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_xfer_pkg::*;
#(
  parameter int unsigned AW = 32,
  localparam int unsigned IW = $clog2(NREG),
  localparam int unsigned CW = $clog2(NREG + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [NREG-1:0] req_mask_i,
  input  logic [AW-1:0]   req_base_i,
  input  logic            req_dec_i,
  input  logic            req_before_i,
  output logic            mem_valid_o,
  input  logic            mem_ready_i,
  output logic [IW-1:0]   mem_reg_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [AW-1:0]   wb_base_o,
  output logic            done_o
);
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  seq_state_e      state_q, state_d;
  logic [NREG-1:0] rem_q, rem_d;
  logic [AW-1:0]   addr_q, addr_d, wb_q, wb_d;
  logic [CW-1:0]   sel_cnt;
  logic [AW-1:0]   start_addr, wb_calc;
  logic [IW-1:0]   cur_idx;
  logic            rem_any;
  logic            accept, xfer;
  logic [NREG-1:0] rem_next;

  mask_popcnt #(.W(NREG)) u_popcnt (
    .mask_i (req_mask_i),
    .cnt_o  (sel_cnt)
  );

  xfer_addr_calc #(.AW(AW), .CW(CW), .WORD_BYTES(WORD_BYTES)) u_addr (
    .base_i   (req_base_i),
    .cnt_i    (sel_cnt),
    .dec_i    (req_dec_i),
    .before_i (req_before_i),
    .start_o  (start_addr),
    .wb_o     (wb_calc)
  );

  lowest_set #(.W(NREG)) u_scan (
    .vec_i (rem_q),
    .idx_o (cur_idx),
    .any_o (rem_any)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign mem_valid_o = (state_q == ST_RUN);
  assign done_o      = (state_q == ST_DONE);
  assign mem_reg_o   = cur_idx;
  assign mem_addr_o  = addr_q;
  assign wb_base_o   = wb_q;

  assign accept   = req_valid_i && req_ready_o;
  assign xfer     = mem_valid_o && mem_ready_i;
  assign rem_next = rem_q & (rem_q - NREG'(1));  // drop lowest set bit

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    addr_d  = addr_q;
    wb_d    = wb_q;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        rem_d   = req_mask_i;
        addr_d  = start_addr;
        wb_d    = wb_calc;
        state_d = (req_mask_i == '0) ? ST_DONE : ST_RUN;
      end
      ST_RUN: if (xfer) begin
        rem_d  = rem_next;
        addr_d = addr_q + STEP;
        if (rem_next == '0) state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      addr_q  <= '0;
      wb_q    <= '0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      addr_q  <= addr_d;
      wb_q    <= wb_d;
    end
  end

  assert_busy_not_ready_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> !req_ready_o);
  assert_run_has_bits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> rem_any);
  assert_reg_ascends_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer |=> (!mem_valid_o || mem_reg_o > $past(mem_reg_o)));
  assert_addr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer |=> (!mem_valid_o || mem_addr_o == $past(mem_addr_o) + STEP));
  assert_stall_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=>
      (mem_valid_o && $stable(mem_addr_o) && $stable(mem_reg_o)));
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_valid_o);
  assert_wb_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && $past(mem_valid_o)) |-> $stable(wb_base_o));
endmodule

// File: tb/blk_xfer_seq_tb.sv
module blk_xfer_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_mask = '0;
  logic [31:0] req_base = '0;
  logic        req_dec = 1'b0;
  logic        req_before = 1'b0;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [3:0]  mem_reg;
  logic [31:0] mem_addr;
  logic [31:0] wb_base;
  logic        done;

  always #(CLK_PERIOD / 2) clk = ~clk;

  blk_xfer_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_mask_i(req_mask), .req_base_i(req_base),
    .req_dec_i(req_dec), .req_before_i(req_before),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready),
    .mem_reg_o(mem_reg), .mem_addr_o(mem_addr),
    .wb_base_o(wb_base), .done_o(done)
  );

  int    checks = 0;
  int    errors = 0;
  string phase  = "R8 reset";
  int    rdy_mode = 0;  // 0 always ready, 1 random, 2 forced low

  // reference model: 0 idle, 1 run, 2 done
  int          m_state = 0;
  int          q_reg[$];
  logic [31:0] q_addr[$];
  logic [31:0] m_wb = '0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] actual=%h expected=%h t=%0t", req, phase, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0;
      q_reg.delete();
      q_addr.delete();
    end else if (m_state == 2) begin
      m_state = 0;
    end else if (m_state == 1) begin
      if (mem_ready) begin
        void'(q_reg.pop_front());
        void'(q_addr.pop_front());
        if (q_reg.size() == 0) m_state = 2;
      end
    end else if (req_valid) begin
      int          n;
      logic [31:0] a;
      n = $countones(req_mask);
      if (!req_dec) begin
        a    = req_before ? req_base + 32'd4 : req_base;
        m_wb = req_base + 32'(4 * n);
      end else begin
        a    = req_before ? req_base - 32'(4 * n) : req_base - 32'(4 * n) + 32'd4;
        m_wb = req_base - 32'(4 * n);
      end
      for (int i = 0; i < 16; i++) begin
        if (req_mask[i]) begin
          q_reg.push_back(i);
          q_addr.push_back(a);
          a = a + 32'd4;
        end
      end
      m_state = (n == 0) ? 2 : 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 ready", 32'(req_ready), 32'(m_state == 0));
      chk("R2 valid", 32'(mem_valid), 32'(m_state == 1));
      if (m_state == 1 && q_reg.size() > 0) begin
        chk("R2 reg", 32'(mem_reg), 32'(q_reg[0]));
        chk("R3 R4 addr", mem_addr, q_addr[0]);
      end
      chk("R7 done", 32'(done), 32'(m_state == 2));
      if (m_state == 2) chk("R6 wb", wb_base, m_wb);
    end
    case (rdy_mode)
      0: mem_ready <= 1'b1;
      1: mem_ready <= 1'($urandom);
      default: mem_ready <= 1'b0;
    endcase
  end

  task automatic run(string ph, logic [15:0] m, logic [31:0] b, logic d, logic bf);
    @(negedge clk);
    phase = ph;
    req_valid = 1'b1; req_mask = m; req_base = b; req_dec = d; req_before = bf;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (m_state != 0) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 ready", 32'(req_ready), 32'd1);
    chk("R8 valid", 32'(mem_valid), 32'd0);
    chk("R8 done", 32'(done), 32'd0);
    rst_n = 1'b1;
    rdy_mode = 0;
    run("R4 up/after", 16'h8421, 32'h1000, 1'b0, 1'b0);
    run("R4 up/before", 16'hA5F0, 32'h2000, 1'b0, 1'b1);
    run("R4 down/after", 16'hA5F0, 32'h3000, 1'b1, 1'b0);
    run("R4 down/before", 16'hA5F0, 32'h3000, 1'b1, 1'b1);
    run("R7 zero mask", 16'h0000, 32'h4000, 1'b1, 1'b1);
    run("R2 full mask back to back", 16'hFFFF, 32'h5000, 1'b0, 1'b0);
    run("R2 top bit only", 16'h8000, 32'h6000, 1'b1, 1'b0);
    run("R9 wrap down", 16'h00FF, 32'h0000_0004, 1'b1, 1'b1);
    run("R9 wrap up", 16'hC003, 32'hFFFF_FFF8, 1'b0, 1'b1);
    // R5 stall and R1 request while busy
    @(negedge clk);
    rdy_mode = 2;
    phase = "R5 stall";
    req_valid = 1'b1; req_mask = 16'h8001; req_base = 32'h7000;
    req_dec = 1'b0; req_before = 1'b0;
    @(negedge clk);
    phase = "R1 R5 busy request";
    req_mask = 16'h0FF0; req_base = 32'h9999_0000; req_dec = 1'b1;
    repeat (4) @(negedge clk);
    rdy_mode = 0;
    repeat (2) @(negedge clk);
    rdy_mode = 2;
    repeat (3) @(negedge clk);
    rdy_mode = 0;
    req_valid = 1'b0;
    while (m_state != 0) @(negedge clk);
    // random phase
    phase = "R1 R2 R5 random";
    rdy_mode = 1;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      req_valid  = 1'($urandom);
      req_dec    = 1'($urandom);
      req_before = 1'($urandom);
      req_base   = $urandom;
      case ($urandom % 4)
        0: req_mask = 16'h0000;
        1: req_mask = 16'hFFFF;
        2: req_mask = 16'(1 << ($urandom % 16));
        default: req_mask = 16'($urandom);
      endcase
    end
    req_valid = 1'b0;
    rdy_mode = 0;
    while (m_state != 0) @(negedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule